// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block is the CPU-facing register front end of a serial and infrared communication controller. The host sees only eight byte locations. Several register banks are multiplexed onto that window. The block decodes each read and write strobe against the current bank and steers it to the right storage. It holds the line control, FIFO control, baud divisor, scratchpad and mode state. It drives the control values toward the serial engine. It also returns the FIFO occupancy counts and a fixed identification byte.

Location 3 is shared in every bank. Data bit 7 of a write to it decides whether the byte is a new line control value or a bank selection. Bank 3 gives read access to copies of the write-only line and FIFO control registers. A lock bit in the bank 0 mode register silently redirects the two divisor byte locations onto two scratchpad bytes, and it also suppresses the fallback request. Extended mode overrides the lock. In that mode the lock has no effect, so the divisor is reachable again and fallback follows its request bit.

Register layout. Location 3 in any bank is the line control / bank select location.
- Bank 0, locations 0 and 1: divisor low and high byte, or scratch 0 and scratch 1 while the lock is effective.
- Bank 0, location 2: FIFO control. It is write-only here and reads 0.
- Bank 0, location 4: mode register. Bit 0 is the lock and bit 1 is the fallback request. Bits 7:2 read 0.
- Bank 1, locations 0 and 1: TX level and RX level.
- Bank 3, locations 0, 1 and 2: identification, line control copy and FIFO control copy.
- Every other bank and location pair is reserved.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the bank is 0, the line control, FIFO control, divisor, scratchpads, lock and fallback request are all 0, and every readable location reads 0 except the identification byte and the level locations.
- R2: A write to location 3 with data bit 7 = 0 loads the full byte into the line control register on the next clock, in any bank, and leaves the bank unchanged.
- R3: A write to location 3 with data bit 7 = 1 sets the bank to data bits 1:0 on the next clock and leaves the line control register unchanged.
- R4: In bank 3, location 1 reads the current line control value and location 2 reads the last value written to bank 0 location 2 (FIFO control). Reading location 3 in any bank also returns the line control value.
- R5: In bank 3, location 0 reads the constant 0x32 (upper nibble 3, revision 2). Writes to it change nothing.
- R6: In bank 1, location 0 reads {2'b00, txLevel} and location 1 reads {2'b00, rxLevel}. Writes to them change nothing.
- R7: While the lock bit (bank 0 location 4, bit 0) is 1 and extMode is 0, bank 0 locations 0 and 1 write and read scratch 0 and scratch 1, the divisor output holds its value, and fallbackEn is 0.
- R8: While extMode is 1, a set lock bit has no effect: bank 0 locations 0 and 1 reach the divisor bytes and fallbackEn follows the fallback request bit.
- R9: Reserved locations read 0, and writes to them change no output and no readable location.
- R10: rdData is 0 whenever rdEn is 0. When rdEn is 1, rdData shows the addressed value in the same cycle.
- R11: With the lock not effective, writes to bank 0 location 0 or 1 update divisor bits 7:0 or 15:8 on the next clock, and reads return those bytes.
- R12: fallbackEn equals the fallback request bit (bank 0 location 4, bit 1) unless the lock is effective, in which case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register location within the window |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational, 0 when not reading |
| txLevel | input | 6 | Transmit FIFO byte count |
| rxLevel | input | 6 | Receive FIFO byte count |
| extMode | input | 1 | Extended mode active; overrides the lock |
| bankSel | output | 2 | Current bank |
| lineCtrl | output | 8 | Line control value to the serial engine |
| fifoCtrl | output | 8 | FIFO control value to the FIFOs |
| divisor | output | 16 | Baud divisor |
| fallbackEn | output | 1 | Fallback enable after lock gating |

## Verification
A bank register that holds the wrong value shows up at once on the bankSel port. It also misroutes the very next access, so a read returns some other location's value in the same cycle. A line control register corrupted by a bank-select write shows on lineCtrl one clock after that write, and also on every later read of location 3 or of the bank 3 copy. A fault in the lock path is visible in the cycle after a divisor-location write, as a moving divisor while locked or a frozen divisor while unlocked. The same fault also shows immediately on fallbackEn.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_DIV0,
    RD_DIV1,
    RD_SCR0,
    RD_SCR1,
    RD_MODE,
    RD_LCR,
    RD_FCR,
    RD_TXLV,
    RD_RXLV,
    RD_ID
  } rdSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic       wrLcr;
    logic       wrBank;
    logic [1:0] wrDiv;
    logic [1:0] wrScr;
    logic       wrFcr;
    logic       wrMode;
    rdSel_e     rdSel;
  } regStrobe_t;

  localparam logic [2:0] CTL_LOC  = 3'd3;
  localparam logic [2:0] MODE_LOC = 3'd4;
  localparam logic [2:0] FCR_LOC  = 3'd2;

endpackage

// File: rtl/uart_bank_ctrl.sv
module uart_bank_ctrl
  import uart_bank_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [2:0]        addr,
  input  logic              wrEn,
  input  logic              wrBit7,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              lockEff,
  output regStrobe_t        strobe
);

  localparam logic [BANK_W-1:0] BANK_MAIN  = BANK_W'(0);
  localparam logic [BANK_W-1:0] BANK_LEVEL = BANK_W'(1);
  localparam logic [BANK_W-1:0] BANK_INFO  = BANK_W'(3);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    if (addr == CTL_LOC) begin
      // shared location: bit 7 tells line control from bank select
      strobe.wrLcr  = wrEn & ~wrBit7;
      strobe.wrBank = wrEn & wrBit7;
      strobe.rdSel  = RD_LCR;
    end else if (bankSel == BANK_MAIN) begin
      case (addr)
        3'd0: begin
          if (lockEff) begin
            strobe.wrScr[0] = wrEn;
            strobe.rdSel    = RD_SCR0;
          end else begin
            strobe.wrDiv[0] = wrEn;
            strobe.rdSel    = RD_DIV0;
          end
        end
        3'd1: begin
          if (lockEff) begin
            strobe.wrScr[1] = wrEn;
            strobe.rdSel    = RD_SCR1;
          end else begin
            strobe.wrDiv[1] = wrEn;
            strobe.rdSel    = RD_DIV1;
          end
        end
        FCR_LOC:  strobe.wrFcr = wrEn;
        MODE_LOC: begin
          strobe.wrMode = wrEn;
          strobe.rdSel  = RD_MODE;
        end
        default: ;
      endcase
    end else if (bankSel == BANK_LEVEL) begin
      case (addr)
        3'd0:    strobe.rdSel = RD_TXLV;
        3'd1:    strobe.rdSel = RD_RXLV;
        default: ;
      endcase
    end else if (bankSel == BANK_INFO) begin
      case (addr)
        3'd0:    strobe.rdSel = RD_ID;
        3'd1:    strobe.rdSel = RD_LCR;
        3'd2:    strobe.rdSel = RD_FCR;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_bank_dp.sv
module uart_bank_dp
  import uart_bank_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         LEVEL_W  = 6,
  parameter int         BANK_W   = 2,
  parameter logic [3:0] REVISION = 4'h2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [LEVEL_W-1:0]   txLevel,
  input  logic [LEVEL_W-1:0]   rxLevel,
  input  logic                 extMode,
  output logic [DATA_W-1:0]    rdData,
  output logic [BANK_W-1:0]    bankSel,
  output logic                 lockEff,
  output logic [DATA_W-1:0]    lineCtrl,
  output logic [DATA_W-1:0]    fifoCtrl,
  output logic [2*DATA_W-1:0]  divisor,
  output logic                 fallbackEn
);

  localparam int          PAD_W   = DATA_W - LEVEL_W;
  localparam int          ID_PAD  = DATA_W - 8;
  localparam logic [7:0]  ID_BYTE = {4'h3, REVISION};

  logic [DATA_W-1:0] scratch [2];
  logic              lockBit;
  logic              fallbackReq;
  logic [DATA_W-1:0] rdVal;

  assign lockEff    = lockBit & ~extMode;
  assign fallbackEn = fallbackReq & ~lockEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel     <= '0;
      lineCtrl    <= '0;
      fifoCtrl    <= '0;
      lockBit     <= 1'b0;
      fallbackReq <= 1'b0;
    end else begin
      if (strobe.wrBank) bankSel  <= wrData[BANK_W-1:0];
      if (strobe.wrLcr)  lineCtrl <= wrData;
      if (strobe.wrFcr)  fifoCtrl <= wrData;
      if (strobe.wrMode) begin
        lockBit     <= wrData[0];
        fallbackReq <= wrData[1];
      end
    end
  end

  // divisor bytes and their overlaid scratchpads
  for (genvar b = 0; b < 2; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divisor[b*DATA_W +: DATA_W] <= '0;
        scratch[b]                  <= '0;
      end else begin
        if (strobe.wrDiv[b]) divisor[b*DATA_W +: DATA_W] <= wrData;
        if (strobe.wrScr[b]) scratch[b]                  <= wrData;
      end
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DIV0: rdVal = divisor[DATA_W-1:0];
      RD_DIV1: rdVal = divisor[2*DATA_W-1:DATA_W];
      RD_SCR0: rdVal = scratch[0];
      RD_SCR1: rdVal = scratch[1];
      RD_MODE: rdVal = {{(DATA_W-2){1'b0}}, fallbackReq, lockBit};
      RD_LCR:  rdVal = lineCtrl;
      RD_FCR:  rdVal = fifoCtrl;
      RD_TXLV: rdVal = {{PAD_W{1'b0}}, txLevel};
      RD_RXLV: rdVal = {{PAD_W{1'b0}}, rxLevel};
      RD_ID:   rdVal = DATA_W'({{ID_PAD{1'b0}}, ID_BYTE});
      default: rdVal = '0;
    endcase
    rdData = rdEn ? rdVal : '0;
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         LEVEL_W  = 6,
  parameter int         BANK_W   = 2,
  parameter logic [3:0] REVISION = 4'h2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          addr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  output logic [DATA_W-1:0]   rdData,
  input  logic [LEVEL_W-1:0]  txLevel,
  input  logic [LEVEL_W-1:0]  rxLevel,
  input  logic                extMode,
  output logic [BANK_W-1:0]   bankSel,
  output logic [DATA_W-1:0]   lineCtrl,
  output logic [DATA_W-1:0]   fifoCtrl,
  output logic [2*DATA_W-1:0] divisor,
  output logic                fallbackEn
);

  regStrobe_t strobe;
  logic       lockEff;

  uart_bank_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .wrBit7  (wrData[DATA_W-1]),
    .bankSel (bankSel),
    .lockEff (lockEff),
    .strobe  (strobe)
  );

  uart_bank_dp #(
    .DATA_W   (DATA_W),
    .LEVEL_W  (LEVEL_W),
    .BANK_W   (BANK_W),
    .REVISION (REVISION)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .extMode    (extMode),
    .rdData     (rdData),
    .bankSel    (bankSel),
    .lockEff    (lockEff),
    .lineCtrl   (lineCtrl),
    .fifoCtrl   (fifoCtrl),
    .divisor    (divisor),
    .fallbackEn (fallbackEn)
  );

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter int DATA_W  = 8,
  parameter int LEVEL_W = 6,
  parameter int BANK_W  = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          addr,
  input logic                wrEn,
  input logic [DATA_W-1:0]   wrData,
  input logic                rdEn,
  input logic [DATA_W-1:0]   rdData,
  input logic [LEVEL_W-1:0]  txLevel,
  input logic                extMode,
  input logic [BANK_W-1:0]   bankSel,
  input logic [DATA_W-1:0]   lineCtrl,
  input logic [2*DATA_W-1:0] divisor,
  input logic                fallbackEn
);

  localparam int PAD_W = DATA_W - LEVEL_W;

  // independent tracking of the lock bit from the host write stream
  logic seenLock;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenLock <= 1'b0;
    else if (wrEn && addr == 3'd4 && bankSel == '0) seenLock <= wrData[0];
  end

  wire ctlWr = wrEn && addr == 3'd3;

  assert_lcr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr && !wrData[DATA_W-1] |=> lineCtrl == $past(wrData) && bankSel == $past(bankSel));

  assert_bank_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr && wrData[DATA_W-1] |=> bankSel == $past(wrData[BANK_W-1:0]) && $stable(lineCtrl));

  assert_id_nibble_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && bankSel == BANK_W'(3) && addr == 3'd0 |-> rdData[7:4] == 4'h3);

  assert_tx_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && bankSel == BANK_W'(1) && addr == 3'd0 |-> rdData == {{PAD_W{1'b0}}, txLevel});

  assert_div_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && seenLock && !extMode && bankSel == '0 && addr < 3'd2 |=> $stable(divisor));

  assert_fallback_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    seenLock && !extMode |-> !fallbackEn);

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

endmodule

bind uart_bank_regs uart_bank_regs_chk #(
  .DATA_W  (DATA_W),
  .LEVEL_W (LEVEL_W),
  .BANK_W  (BANK_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdEn       (rdEn),
  .rdData     (rdData),
  .txLevel    (txLevel),
  .extMode    (extMode),
  .bankSel    (bankSel),
  .lineCtrl   (lineCtrl),
  .divisor    (divisor),
  .fallbackEn (fallbackEn)
);

// File: tb/tb_uart_bank_regs.sv
module tb_uart_bank_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [5:0]  txLevel = '0;
  logic [5:0]  rxLevel = '0;
  logic        extMode = 1'b0;
  logic [1:0]  bankSel;
  logic [7:0]  lineCtrl;
  logic [7:0]  fifoCtrl;
  logic [15:0] divisor;
  logic        fallbackEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  uart_bank_regs dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .txLevel(txLevel), .rxLevel(rxLevel),
    .extMode(extMode), .bankSel(bankSel), .lineCtrl(lineCtrl),
    .fifoCtrl(fifoCtrl), .divisor(divisor), .fallbackEn(fallbackEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  logic [1:0]  mBank;
  logic [7:0]  mLcr, mFcr, mScr0, mScr1;
  logic [15:0] mDiv;
  logic        mLock, mFb;

  function automatic logic lockOn();
    return mLock && !extMode;
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    if (a == 3'd3) return mLcr;
    case (mBank)
      2'd0: case (a)
              3'd0: return lockOn() ? mScr0 : mDiv[7:0];
              3'd1: return lockOn() ? mScr1 : mDiv[15:8];
              3'd4: return {6'b0, mFb, mLock};
              default: return 8'h00;
            endcase
      2'd1: case (a)
              3'd0: return {2'b00, txLevel};
              3'd1: return {2'b00, rxLevel};
              default: return 8'h00;
            endcase
      2'd3: case (a)
              3'd0: return 8'h32;
              3'd1: return mLcr;
              3'd2: return mFcr;
              default: return 8'h00;
            endcase
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] a);
    if (a == 3'd3) return "R4";
    case (mBank)
      2'd0: return (a < 3'd2) ? (lockOn() ? "R7" : "R11") : (a == 3'd4 ? "R12" : "R9");
      2'd1: return (a < 3'd2) ? "R6" : "R9";
      2'd3: return (a == 3'd0) ? "R5" : (a < 3'd3 ? "R4" : "R9");
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd3) begin
      if (d[7]) mBank = d[1:0];
      else      mLcr  = d;
    end else if (mBank == 2'd0) begin
      case (a)
        3'd0: if (lockOn()) mScr0 = d; else mDiv[7:0]  = d;
        3'd1: if (lockOn()) mScr1 = d; else mDiv[15:8] = d;
        3'd2: mFcr = d;
        3'd4: begin mLock = d[0]; mFb = d[1]; end
        default: ;
      endcase
    end
  endtask

  task automatic checkOutputs(input string req);
    check(req, {14'b0, bankSel}, {14'b0, mBank});
    check(req, {8'b0, lineCtrl}, {8'b0, mLcr});
    check(req, {8'b0, fifoCtrl}, {8'b0, mFcr});
    check(req, divisor, mDiv);
    check(req, {15'b0, fallbackEn}, {15'b0, mFb && !lockOn()});
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
    checkOutputs(req);
  endtask

  task automatic doRead(input logic [2:0] a, input string req);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1;
    check(req, {8'b0, rdData}, {8'b0, expRead(a)});
    rdEn = 1'b0;
    #1;
    check("R10", {8'b0, rdData}, 16'h0000);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    mBank = 0; mLcr = 0; mFcr = 0; mScr0 = 0; mScr1 = 0; mDiv = 0; mLock = 0; mFb = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkOutputs("R1");
    for (int a = 0; a < 8; a++) doRead(3'(a), "R1");

    // R11: divisor bytes unlocked
    doWrite(3'd0, 8'h34, "R11");
    doWrite(3'd1, 8'h12, "R11");
    doRead(3'd0, "R11");
    doRead(3'd1, "R11");

    // R2: line control from bank 2, bank unchanged
    doWrite(3'd3, 8'h82, "R3");
    doWrite(3'd3, 8'h5A, "R2");
    doRead(3'd3, "R2");
    // R3: bank select with extra high bits leaves line control alone
    doWrite(3'd3, 8'hFF, "R3");
    check("R3", {14'b0, bankSel}, 16'd3);
    check("R3", {8'b0, lineCtrl}, 16'h005A);

    // R4 / R5 in bank 3
    doRead(3'd1, "R4");
    doRead(3'd0, "R5");
    doWrite(3'd0, 8'hAA, "R5");
    doRead(3'd0, "R5");
    // R9: reserved writes ignored
    for (int a = 4; a < 8; a++) begin
      doWrite(3'(a), 8'hC3, "R9");
      doRead(3'(a), "R9");
    end

    // R4: FIFO control copy
    doWrite(3'd3, 8'h80, "R3");
    doWrite(3'd2, 8'hC7, "R4");
    doRead(3'd2, "R9");
    doWrite(3'd3, 8'h83, "R3");
    doRead(3'd2, "R4");

    // R6: levels at the top count, writes ignored
    doWrite(3'd3, 8'h81, "R3");
    txLevel = 6'h3F; rxLevel = 6'h15;
    doRead(3'd0, "R6");
    doRead(3'd1, "R6");
    doWrite(3'd0, 8'hFF, "R6");
    doRead(3'd0, "R6");

    // R7 / R12: lock engaged with fallback requested
    doWrite(3'd3, 8'h80, "R3");
    doWrite(3'd4, 8'h03, "R12");
    check("R12", {15'b0, fallbackEn}, 16'd0);
    doWrite(3'd0, 8'hE1, "R7");
    doWrite(3'd1, 8'hE2, "R7");
    check("R7", divisor, 16'h1234);
    doRead(3'd0, "R7");
    doRead(3'd1, "R7");

    // R8: extended mode overrides lock
    @(negedge clk); extMode = 1'b1;
    #1 check("R8", {15'b0, fallbackEn}, 16'd1);
    doRead(3'd0, "R8");
    doWrite(3'd1, 8'h77, "R8");
    check("R8", divisor, 16'h7734);
    @(negedge clk); extMode = 1'b0;
    doRead(3'd1, "R7");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      txLevel = 6'($urandom);
      rxLevel = 6'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        @(negedge clk); extMode = ~extMode;
      end
      if ($urandom_range(0, 1) == 1) doWrite(a, d, (a == 3'd3) ? (d[7] ? "R3" : "R2") : reqOf(a));
      else                           doRead(a, reqOf(a));
    end

    finishRun();
  end

endmodule